// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a synchronous up-counter made of identical 4-bit stages. Each stage can be cleared, preset from a data input, counted up or held, and every change lands on the rising clock edge. Each stage also drives a combinational terminal-count flag. That flag feeds the carry enable of the next stage, so the chain behaves as one wide binary counter without ripple through the flip-flops.

The clear input is active low and synchronous. It doubles as the block's reset. The clear input can also be driven from an outside decode of the count, which makes the counter wrap early and gives a shorter modulus.

The stage width and the number of stages are parameters. The top module builds the chain with a generate loop.

Top module: `cnt_chain`

## Requirements
- R1: When clear_n is low at a rising edge, count becomes all zeros on that edge, whatever load_n, cnt_en_p and cnt_en_t are.
- R2: When clear_n is high and load_n is low at a rising edge, count takes the value of din, whatever the levels of both count enables.
- R3: When clear_n, load_n, cnt_en_p and cnt_en_t are all high at a rising edge, count increases by exactly one.
- R4: Counting from the all-ones value gives all zeros, with no extra state in between.
- R5: When clear and load are inactive and either count enable is low, count keeps its value across the edge.
- R6: tc is high exactly when cnt_en_t is high and count is all ones. cnt_en_p has no effect on tc.
- R7: tc is combinational. It follows a change of cnt_en_t within the same clock cycle, before any edge.
- R8: A stage above the lowest advances only on an edge where every stage below it holds all ones. The whole chain therefore counts as one binary number.
- R9: If clear_n is driven low while count equals a chosen value V, the counter cycles through 0..V and has modulus V+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Synchronous clear, active low; highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable shared by every stage; does not gate tc |
| cnt_en_t | input | 1 | Carry count enable into the lowest stage; gates tc |
| din | input | STAGE_W*STAGES | Preset value |
| count | output | STAGE_W*STAGES | Current count |
| tc | output | 1 | Terminal count of the whole chain |

## Verification
The bench builds the block with two 4-bit stages, which gives an 8-bit counter. With this size, the carry from the low stage into the upper stage is reached with short loads and counts. The full wrap from 255 to 0 is also within reach. A decoded clear at count 9 exercises the shortened modulus. The terminal-count flag is checked between edges, both right after the carry enable changes and while the parallel enable is low at all ones.

// File: rtl/cnt_pkg.sv
// Shared types for the cascadable counter.
package cnt_pkg;
    // Operation chosen for a stage on the next rising edge, listed by rising priority.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;
endpackage

// File: rtl/stage_ctl.sv
// Priority decode for one stage: clear beats load, load beats counting.
// Assumes all control inputs are synchronous to the stage clock.
module stage_ctl
    import cnt_pkg::*;
(
    input  logic      clear_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output stage_op_e op
);
    // Select the operation for the coming edge.
    always_comb begin
        if (!clear_n)         op = OP_CLEAR;
        else if (!load_n)     op = OP_LOAD;
        else if (en_p && en_t) op = OP_INC;
        else                  op = OP_HOLD;
    end
endmodule

// File: rtl/stage_reg.sv
// State register of one stage. Applies the decoded operation on the rising edge.
// Increment wraps naturally at the width limit.
module stage_reg
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  stage_op_e    op,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    // Update the stage value according to the operation.
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= d;
            OP_INC:   q <= q + ONE;
            default:  q <= q;
        endcase
    end
endmodule

// File: rtl/stage_tc.sv
// Terminal-count flag of one stage: carry enable AND value at all ones.
// Purely combinational, so a cascade forms a look-ahead carry chain.
module stage_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en_t,
    output logic         tc
);
    // Flag all ones when the carry enable is present.
    always_comb tc = en_t && (q == {W{1'b1}});
endmodule

// File: rtl/cnt_stage.sv
// One counter stage: control decode, state register and terminal-count flag.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tc
);
    stage_op_e op;

    stage_ctl u_ctl (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .op      (op)
    );

    stage_reg #(.W(W)) u_reg (
        .clk (clk),
        .op  (op),
        .d   (d),
        .q   (q)
    );

    stage_tc #(.W(W)) u_tc (
        .q    (q),
        .en_t (en_t),
        .tc   (tc)
    );
endmodule

// File: rtl/cnt_chain.sv
// Chain of STAGES counter stages. The stages share clock, clear, load and the
// parallel enable. Each stage's carry enable is the terminal count of the stage
// below it. The lowest stage takes cnt_en_t. tc is the top stage's flag.
module cnt_chain #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        clear_n,
    input  logic                        load_n,
    input  logic                        cnt_en_p,
    input  logic                        cnt_en_t,
    input  logic [STAGE_W*STAGES-1:0]   din,
    output logic [STAGE_W*STAGES-1:0]   count,
    output logic                        tc
);
    localparam int TOT = STAGE_W * STAGES;

    logic [STAGES:0] carry;

    // Feed the external carry enable into the lowest stage.
    always_comb carry[0] = cnt_en_t;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .en_p    (cnt_en_p),
            .en_t    (carry[k]),
            .d       (din[k*STAGE_W +: STAGE_W]),
            .q       (count[k*STAGE_W +: STAGE_W]),
            .tc      (carry[k+1])
        );
    end

    // The top stage's flag is the chain's terminal count.
    always_comb tc = carry[STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
// Assertion checker for cnt_chain, attached with bind below.
// Assumes the first clock edges see clear_n low so that count is defined.
module cnt_chain_chk #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input logic                      clk,
    input logic                      clear_n,
    input logic                      load_n,
    input logic                      cnt_en_p,
    input logic                      cnt_en_t,
    input logic [STAGE_W*STAGES-1:0] din,
    input logic [STAGE_W*STAGES-1:0] count,
    input logic                      tc
);
    localparam int TOT = STAGE_W * STAGES;
    localparam logic [TOT-1:0] ALL1 = {TOT{1'b1}};

    logic armed = 1'b0;
    // Arm checks once one edge has passed so that $past has history.
    always_ff @(posedge clk) armed <= 1'b1;

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> count == '0);

    a_r2_load_din: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> count == $past(din));

    a_r3_increment: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cnt_en_p && cnt_en_t && count != ALL1)
        |=> count == $past(count) + TOT'(1));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cnt_en_p && cnt_en_t && count == ALL1)
        |=> count == '0);

    a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

    a_r6_tc_gate: assert property (@(posedge clk) disable iff (!armed)
        tc == (cnt_en_t && count == ALL1));

    if (STAGES > 1) begin : g_casc
        a_r8_upper_waits: assert property (@(posedge clk) disable iff (!armed)
            (clear_n && load_n && count[STAGE_W-1:0] != {STAGE_W{1'b1}})
            |=> $stable(count[TOT-1:STAGE_W]));
    end
endmodule

bind cnt_chain cnt_chain_chk #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .cnt_en_p (cnt_en_p),
    .cnt_en_t (cnt_en_t),
    .din      (din),
    .count    (count),
    .tc       (tc)
);

// File: tb/cnt_chain_tb.sv
// Bench for cnt_chain with a behavioural integer reference model.
module cnt_chain_tb;
    localparam int SW  = 4;
    localparam int NS  = 2;
    localparam int TOT = SW * NS;
    localparam int MODV = 1 << TOT;

    logic           clk = 1'b0;
    logic           clear_n = 1'b0;
    logic           load_n = 1'b1;
    logic           cnt_en_p = 1'b0;
    logic           cnt_en_t = 1'b0;
    logic [TOT-1:0] din = '0;
    logic [TOT-1:0] count;
    logic           tc;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #5 clk = ~clk;

    cnt_chain #(.STAGE_W(SW), .STAGES(NS)) u_dut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
        .cnt_en_t(cnt_en_t), .din(din), .count(count), .tc(tc)
    );

    function automatic logic exp_tc();
        return cnt_en_t && (model == MODV - 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check tc between edges, step model, check count.
    task automatic cyc(input logic cl, input logic ld, input logic p, input logic t,
                       input int d, input string req);
        clear_n = cl; load_n = ld; cnt_en_p = p; cnt_en_t = t; din = TOT'(d);
        #1;
        check({req, "/R7 tc before edge"}, int'(tc), int'(exp_tc()));
        @(posedge clk);
        if (!cl)          model = 0;
        else if (!ld)     model = d % MODV;
        else if (p && t)  model = (model + 1) % MODV;
        @(negedge clk);
        check(req, int'(count), model);
        check({req, "/R6 tc"}, int'(tc), int'(exp_tc()));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: clear with load and enables active
        cyc(0, 0, 1, 1, 8'h77, "R1");
        cyc(0, 0, 1, 1, 8'h77, "R1");
        // R2: load with enables low, then high
        cyc(1, 0, 0, 0, 8'h5A, "R2");
        cyc(1, 0, 1, 1, 8'hC3, "R2");
        // R3: count several cycles
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 0, "R3");
        // R5: hold with each enable low
        cyc(1, 1, 0, 1, 0, "R5");
        cyc(1, 1, 1, 0, 0, "R5");
        cyc(1, 1, 0, 0, 0, "R5");
        // R8: carry from low stage into upper stage
        cyc(1, 0, 0, 0, 8'h0E, "R2");
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, "R8");
        // R6/R7: at all ones, tc follows cnt_en_t, ignores cnt_en_p
        cyc(1, 0, 0, 0, 8'hFF, "R2");
        cyc(1, 1, 0, 1, 0, "R6");
        cyc(1, 1, 0, 0, 0, "R7");
        cyc(1, 1, 1, 0, 0, "R6");
        // R4: wrap from all ones to zero
        cyc(1, 1, 1, 1, 0, "R4");
        cyc(1, 0, 0, 0, 8'hFD, "R2");
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 0, "R4");
        // R1: clear beats load at a nonzero count
        cyc(0, 0, 1, 1, 8'h33, "R1");
        // R9: decoded clear at 9 gives modulus 10
        for (int i = 0; i < 25; i++) begin
            cyc((count != TOT'(9)), 1, 1, 1, 0, "R9");
        end
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule